// File: doc/BRIEF.md
# Pin Controller with Edge-Triggered Interrupts

This block controls thirteen general-purpose pads on behalf of a register-driven host. Every pad has a six-bit drive register that sets its direction, its driver style (open-drain or push-pull), a two-bit pull code with a pull enable, and the value to drive. Every pad also has a sense register. It returns the pad level after a two-flop synchronizer, and it holds a two-bit edge code. Each pad's edge detector uses that code to pick one of four modes: off, falling, rising or both.

Detected edges latch into two status groups of uneven width. Pads 0 to 6 form the low group and pads 7 to 12 the high group. Each group has a mask register beside it. Software clears a status bit by writing a one to it. The block drives one interrupt line, which is raised while any status bit is set and its mask bit is clear. The host port is a plain synchronous write strobe with address and data. Read data is returned combinationally from the address.

Top module: `gpio_ctl_top`

## Requirements
- R1: After reset, every pad is an input with its output enable low. All edge codes are off. Both status registers read 0. The low mask reads 0x7F and the high mask reads 0x3F. The interrupt is low.
- R2: The drive register of pad p is at 0x4E44+p. Its fields are: bit 0 output value, bits 2:1 pull code, bit 3 pull enable, bit 4 driver style (1 push-pull), bit 5 direction (1 output). Bits 7:6 read 0. On the pad side, `pin_out[p]` equals bit 0, `pull_en[p]` equals bit 3, and `pull_sel[2p+1:2p]` equals bits 2:1.
- R3: The sense register of pad p is at 0x4E51+p. Bit 0 returns the pad level through two synchronizer flops. Bits 2:1 hold the edge code and read back as written. Bits 7:3 read 0.
- R4: The edge codes are 00 off, 01 falling, 10 rising and 11 both. A synchronized transition that matches the code sets the pad's status bit, three clock edges after the pad input changes. Transitions that do not match set nothing.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R6: When an edge sets a status bit in the same cycle that a write-one clears it, the bit ends up set.
- R7: A status bit latches whatever its mask bit is. The interrupt is high exactly when some status bit is set with its mask bit at 0.
- R8: In push-pull style, the output enable follows the direction bit. In open-drain style, the output enable is high only while the direction bit is 1 and the output value is 0.
- R9: The low group holds pads 0 to 6 in bits 6:0, with status at 0x4E0B and mask at 0x4E19. The high group holds pads 7 to 12 in bits 5:0, with status at 0x4E0C and mask at 0x4E1A. Bits above a group's width read 0 and ignore writes.
- R10: An address outside the map reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register address |
| reg_wr | input | 1 | Write strobe, captured on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pin_in | input | 13 | Pad input levels (asynchronous) |
| pin_out | output | 13 | Value to drive on each pad |
| pin_oe | output | 13 | Pad output enable |
| pull_en | output | 13 | Pull resistor enable |
| pull_sel | output | 26 | Two-bit pull code per pad |
| irq | output | 1 | Combined interrupt |

## Verification
The bench aims a write-one-clear at the exact cycle in which an edge lands. A design that lets the clear win would lose that edge, and the status would read 0. It toggles pad 12, the top bit of the short group, to catch an off-by-one in the group split: such a design would report the edge in the wrong register or bit. It writes all ones to the masks and to an unmapped address. A design that decodes loosely would then read back upper bits, or would disturb a neighbouring register. The random phase mixes edge codes, mask values and partial clears, so that a wrong edge polarity, or a mask that gates latching instead of the interrupt, shows up as a status or interrupt mismatch.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    // Edge-sense code held in bits 2:1 of a sense register
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    // Drive register layout
    localparam int DRV_W      = 6;
    localparam int DRV_VAL    = 0;
    localparam int DRV_PULL_LO = 1;
    localparam int DRV_PULLEN = 3;
    localparam int DRV_PP     = 4;
    localparam int DRV_DIR    = 5;

endpackage

// File: rtl/gpio_pin_edge.sv
module gpio_pin_edge
    import gpio_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_i,
    input  edge_mode_e mode_i,
    output logic       level_o,
    output logic       hit_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pad_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        unique case (mode_i)
            EDGE_OFF:  hit_o = 1'b0;
            EDGE_FALL: hit_o = prev_q & ~sync_q;
            EDGE_RISE: hit_o = ~prev_q & sync_q;
            EDGE_BOTH: hit_o = prev_q ^ sync_q;
        endcase
    end

    assign level_o = sync_q;

    // R3: level comes out of the second synchronizer stage
    a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q == $past(meta_q));

    // R4: a rising-only hit always leaves the level high
    a_r4_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && mode_i == EDGE_RISE) |-> sync_q);

    // R4: a falling-only hit always leaves the level low
    a_r4_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && mode_i == EDGE_FALL) |-> !sync_q);

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_d_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o <= '0;
            mask_o <= '1;
        end else begin
            stat_o <= (stat_o & ~clr_i) | set_i;
            if (mask_we_i) begin
                mask_o <= mask_d_i;
            end
        end
    end

    assign pend_o = |(stat_o & ~mask_o);

    // R6: a detected edge is always recorded, even against a clear
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

    // R5: a clear with no competing edge removes the bits
    a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0 && set_i == '0) |=> ((stat_o & $past(clr_i)) == '0));

    // R1: masks come out of reset fully set
    a_r1_mask_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_o == '1));

endmodule

// File: rtl/gpio_ctl_top.sv
module gpio_ctl_top
    import gpio_ctl_pkg::*;
#(
    parameter int            NPIN      = 13,
    parameter int            GRP0_PINS = 7,
    parameter int            AW        = 16,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] DRV_BASE  = 16'h4E44,
    parameter logic [AW-1:0] SNS_BASE  = 16'h4E51,
    parameter logic [AW-1:0] STAT_BASE = 16'h4E0B,
    parameter logic [AW-1:0] MASK_BASE = 16'h4E19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pull_en,
    output logic [2*NPIN-1:0] pull_sel,
    output logic              irq
);

    localparam int GRP1_PINS = NPIN - GRP0_PINS;

    logic [DRV_W-1:0] drv_q [NPIN];
    edge_mode_e       mode_q [NPIN];
    logic [NPIN-1:0]  level;
    logic [NPIN-1:0]  hit;
    logic [NPIN-1:0]  pp_vec;

    logic [GRP0_PINS-1:0] stat0, mask0;
    logic [GRP1_PINS-1:0] stat1, mask1;
    logic                 pend0, pend1;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[DW-1:DRV_W];

    // Per-pad configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIN; i++) begin
                drv_q[i]  <= '0;
                mode_q[i] <= EDGE_OFF;
            end
        end else if (reg_wr) begin
            for (int i = 0; i < NPIN; i++) begin
                if (reg_addr == DRV_BASE + AW'(i)) begin
                    drv_q[i] <= reg_wdata[DRV_W-1:0];
                end
                if (reg_addr == SNS_BASE + AW'(i)) begin
                    mode_q[i] <= edge_mode_e'(reg_wdata[2:1]);
                end
            end
        end
    end

    // Per-pad pad drive and edge sensing
    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pad
            assign pp_vec[p]          = drv_q[p][DRV_PP];
            assign pin_out[p]         = drv_q[p][DRV_VAL];
            assign pull_en[p]         = drv_q[p][DRV_PULLEN];
            assign pull_sel[2*p +: 2] = drv_q[p][DRV_PULL_LO +: 2];
            assign pin_oe[p]          = drv_q[p][DRV_DIR] &
                                        (drv_q[p][DRV_PP] | ~drv_q[p][DRV_VAL]);

            gpio_pin_edge u_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .pad_i   (pin_in[p]),
                .mode_i  (mode_q[p]),
                .level_o (level[p]),
                .hit_o   (hit[p])
            );
        end
    endgenerate

    // Status and mask groups
    logic stat0_sel, stat1_sel, mask0_sel, mask1_sel;
    assign stat0_sel = reg_wr && (reg_addr == STAT_BASE);
    assign stat1_sel = reg_wr && (reg_addr == STAT_BASE + AW'(1));
    assign mask0_sel = reg_wr && (reg_addr == MASK_BASE);
    assign mask1_sel = reg_wr && (reg_addr == MASK_BASE + AW'(1));

    gpio_irq_group #(.W(GRP0_PINS)) u_grp0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (hit[GRP0_PINS-1:0]),
        .clr_i     (stat0_sel ? reg_wdata[GRP0_PINS-1:0] : '0),
        .mask_we_i (mask0_sel),
        .mask_d_i  (reg_wdata[GRP0_PINS-1:0]),
        .stat_o    (stat0),
        .mask_o    (mask0),
        .pend_o    (pend0)
    );

    gpio_irq_group #(.W(GRP1_PINS)) u_grp1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (hit[NPIN-1:GRP0_PINS]),
        .clr_i     (stat1_sel ? reg_wdata[GRP1_PINS-1:0] : '0),
        .mask_we_i (mask1_sel),
        .mask_d_i  (reg_wdata[GRP1_PINS-1:0]),
        .stat_o    (stat1),
        .mask_o    (mask1),
        .pend_o    (pend1)
    );

    assign irq = pend0 | pend1;

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NPIN; i++) begin
            if (reg_addr == DRV_BASE + AW'(i)) begin
                reg_rdata = DW'(drv_q[i]);
            end
            if (reg_addr == SNS_BASE + AW'(i)) begin
                reg_rdata = DW'({mode_q[i], level[i]});
            end
        end
        if (reg_addr == STAT_BASE)          reg_rdata = DW'(stat0);
        if (reg_addr == STAT_BASE + AW'(1)) reg_rdata = DW'(stat1);
        if (reg_addr == MASK_BASE)          reg_rdata = DW'(mask0);
        if (reg_addr == MASK_BASE + AW'(1)) reg_rdata = DW'(mask1);
    end

    // R8: an open-drain pad never actively drives a one
    a_r8_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_out & ~pp_vec) == '0);

    // R7: the interrupt needs some latched status behind it
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|stat0) || (|stat1)));

    // R1: no pad drives right after reset
    a_r1_oe_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0));

endmodule

// File: tb/gpio_ctl_top_test.sv
`timescale 1ns/1ps
module gpio_ctl_top_test;

    localparam logic [15:0] DRV  = 16'h4E44;
    localparam logic [15:0] SNS  = 16'h4E51;
    localparam logic [15:0] STA  = 16'h4E0B;
    localparam logic [15:0] MSK  = 16'h4E19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [12:0] pin_in = '0;
    logic [12:0] pin_out, pin_oe, pull_en;
    logic [25:0] pull_sel;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_ctl_top uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
        .pull_sel(pull_sel), .irq(irq)
    );

    function automatic logic edge_fires(logic [1:0] m, logic o, logic n);
        case (m)
            2'b00:   return 1'b0;
            2'b01:   return o & ~n;
            2'b10:   return ~o & n;
            default: return o ^ n;
        endcase
    endfunction

    function automatic logic irq_model(logic [12:0] st, logic [12:0] mk);
        return |(st & ~mk);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic toggle(input int p);
        pin_in[p] = ~pin_in[p];
        repeat (4) @(negedge clk);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0]  d;
        logic [12:0] exp_stat;
        logic [12:0] mk;
        logic [1:0]  mode [13];
        void'($urandom(32'h5EED_0001));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(MSK, d);           chk("R1 mask0", d, 8'h7F);
        rd(MSK + 16'd1, d);   chk("R1 mask1", d, 8'h3F);
        rd(STA, d);           chk("R1 stat0", d, 0);
        rd(STA + 16'd1, d);   chk("R1 stat1", d, 0);
        chk("R1 oe", pin_oe, 0);
        chk("R1 irq", irq, 0);
        rd(DRV + 16'd3, d);   chk("R1 drv3", d, 0);
        rd(SNS + 16'd3, d);   chk("R1 sns3", d, 0);

        // R2 drive register fields
        wr(DRV + 16'd4, 8'hFF);
        rd(DRV + 16'd4, d);   chk("R2 readback", d, 8'h3F);
        chk("R2 pin_out", pin_out[4], 1);
        chk("R2 pull_en", pull_en[4], 1);
        chk("R2 pull_sel", pull_sel[9:8], 3);
        wr(DRV + 16'd4, 8'h0A);
        chk("R2 pull_sel 01", pull_sel[9:8], 1);
        chk("R2 pull_en on", pull_en[4], 1);
        chk("R2 pin_out low", pin_out[4], 0);

        // R8 output enable rules
        wr(DRV + 16'd4, 8'h31); chk("R8 pp out1", pin_oe[4], 1);
        wr(DRV + 16'd4, 8'h21); chk("R8 od out1", pin_oe[4], 0);
        wr(DRV + 16'd4, 8'h20); chk("R8 od out0", pin_oe[4], 1);
        wr(DRV + 16'd4, 8'h11); chk("R8 pp input", pin_oe[4], 0);
        wr(DRV + 16'd4, 8'h00);

        // R3 sense register
        toggle(9);
        rd(SNS + 16'd9, d);   chk("R3 level high", d, 8'h01);
        wr(SNS + 16'd9, 8'hFE);
        rd(SNS + 16'd9, d);   chk("R3 code readback", d, 8'h07);
        wr(SNS + 16'd9, 8'h00);
        rd(SNS + 16'd9, d);   chk("R3 code cleared", d, 8'h01);
        toggle(9);
        rd(STA + 16'd1, d);   chk("R4 off no status", d, 0);

        // R4 edge codes on pad 2
        wr(SNS + 16'd2, 8'h04);
        toggle(2); rd(STA, d); chk("R4 rise hit", d, 8'h04);
        wr(STA, 8'h04); rd(STA, d); chk("R5 clear", d, 0);
        toggle(2); rd(STA, d); chk("R4 rise ignores fall", d, 0);
        wr(SNS + 16'd2, 8'h02);
        toggle(2); rd(STA, d); chk("R4 fall ignores rise", d, 0);
        toggle(2); rd(STA, d); chk("R4 fall hit", d, 8'h04);
        wr(STA, 8'h04);
        wr(SNS + 16'd2, 8'h06);
        toggle(2); rd(STA, d); chk("R4 both rise", d, 8'h04);
        wr(STA, 8'h04);
        toggle(2); rd(STA, d); chk("R4 both fall", d, 8'h04);
        wr(STA, 8'h04);
        wr(SNS + 16'd2, 8'h00);
        toggle(2); rd(STA, d); chk("R4 off", d, 0);

        // R9 pad 12 lands in high group bit 5
        wr(SNS + 16'd12, 8'h06);
        toggle(12);
        rd(STA + 16'd1, d); chk("R9 high group bit5", d, 8'h20);
        rd(STA, d);         chk("R9 low group clean", d, 0);

        // R5 write-zero and other-bit writes keep status
        wr(STA + 16'd1, 8'h00); rd(STA + 16'd1, d); chk("R5 write zero", d, 8'h20);
        wr(STA + 16'd1, 8'h1F); rd(STA + 16'd1, d); chk("R5 other bits", d, 8'h20);
        wr(STA + 16'd1, 8'h20); rd(STA + 16'd1, d); chk("R5 w1c", d, 0);

        // R7 mask gates interrupt, not latching
        toggle(12);
        rd(STA + 16'd1, d); chk("R7 latched while masked", d, 8'h20);
        chk("R7 masked irq", irq, 0);
        wr(MSK + 16'd1, 8'h1F); chk("R7 unmasked irq", irq, 1);
        wr(MSK + 16'd1, 8'h3F); chk("R7 remasked irq", irq, 0);
        wr(STA + 16'd1, 8'h20);

        // R6 edge and clear in the same cycle
        pin_in[12] = ~pin_in[12];
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr(STA + 16'd1, 8'h20);
        rd(STA + 16'd1, d); chk("R6 set wins", d, 8'h20);
        wr(STA + 16'd1, 8'h20);
        rd(STA + 16'd1, d); chk("R6 later clear", d, 0);

        // R9 upper bits
        wr(MSK + 16'd1, 8'hFF); rd(MSK + 16'd1, d); chk("R9 mask1 width", d, 8'h3F);
        wr(MSK, 8'hFF);         rd(MSK, d);         chk("R9 mask0 width", d, 8'h7F);
        wr(STA, 8'hFF);         rd(STA, d);         chk("R9 stat0 stays", d, 0);

        // R10 unmapped addresses
        wr(16'h4E5E, 8'hFF); rd(16'h4E5E, d); chk("R10 unmapped read", d, 0);
        wr(16'h4E43, 8'hFF); rd(16'h4E43, d); chk("R10 below map", d, 0);
        rd(DRV, d);          chk("R10 drv0 untouched", d, 0);
        rd(DRV + 16'd12, d); chk("R10 drv12 untouched", d, 0);
        chk("R10 irq quiet", irq, 0);

        // Random phase
        for (int i = 0; i < 13; i++) begin
            wr(SNS + 16'(i), 8'h00);
            mode[i] = 2'b00;
        end
        exp_stat = '0;
        mk = 13'h1FFF;
        for (int it = 0; it < 300; it++) begin
            int p;
            int op;
            p  = $urandom_range(0, 12);
            op = $urandom_range(0, 3);
            case (op)
                0: begin
                    mode[p] = 2'($urandom_range(0, 3));
                    wr(SNS + 16'(p), {5'b0, mode[p], 1'b0});
                end
                1: begin
                    logic o;
                    o = pin_in[p];
                    toggle(p);
                    if (edge_fires(mode[p], o, ~o)) exp_stat[p] = 1'b1;
                end
                2: begin
                    logic [7:0] v;
                    v = 8'($urandom);
                    if (p < 7) begin
                        wr(MSK, v); mk[6:0] = v[6:0];
                    end else begin
                        wr(MSK + 16'd1, v); mk[12:7] = v[5:0];
                    end
                end
                default: begin
                    logic [7:0] v;
                    v = 8'($urandom);
                    if (p < 7) begin
                        wr(STA, v); exp_stat[6:0] = exp_stat[6:0] & ~v[6:0];
                    end else begin
                        wr(STA + 16'd1, v); exp_stat[12:7] = exp_stat[12:7] & ~v[5:0];
                    end
                end
            endcase
            rd(STA, d);         chk("R4 random stat0", d, {1'b0, exp_stat[6:0]});
            rd(STA + 16'd1, d); chk("R5 random stat1", d, {2'b0, exp_stat[12:7]});
            chk("R7 random irq", irq, irq_model(exp_stat, mk));
        end

        done = 1'b1;
        report();
    end

endmodule